// File: doc/BRIEF.md
# Converter Result FIFO with Serial Readout

This block keeps the most recent 12-bit converter results in a small circular store of up to sixteen slots. A host drains the store over an SPI-style serial port: chip select low starts a read, and every group of sixteen serial clocks delivers one word. Each word holds the stored result and the slot index it came from. The host can keep clocking to stream successive words, and it can stop after any complete word. If the host catches up with the writer, the block repeats the newest result instead of returning empty data. A word cut short by chip select rising is not consumed.

The store depth and an interrupt slot are set by configuration inputs. The interrupt flag rises when a write lands in the chosen slot, and it falls when the host starts a read. The serial clock and chip select are asynchronous to the system clock. They pass through synchronizers, and edges are detected in the system clock domain.

The readout sequencer has three states. ST_IDLE waits with chip select high. ST_SHIFT sends the bits of a word. ST_WORD_END follows the sixteenth rising serial clock edge. The transitions are:
- ST_IDLE to ST_SHIFT on the chip select falling edge, which loads a word.
- ST_SHIFT to ST_WORD_END on the sixteenth rising serial clock edge, which consumes the word.
- ST_WORD_END to ST_SHIFT on the next falling serial clock edge, which loads the next word.
- ST_SHIFT or ST_WORD_END to ST_IDLE on the chip select rising edge.

Top module: `rfifo_top`

## Requirements
- R1: Each serial word is 16 bits, sent MSB first. Bits 15..4 carry the 12-bit result and bits 3..0 carry the slot index the result was read from.
- R2: While chip select is high, sdo is 0. After chip select falls, the first bit appears before the first rising serial clock edge. sdo changes only after falling serial clock edges and holds steady while the serial clock is high.
- R3: The read pointer advances after the sixteenth rising serial clock edge of a word. While chip select stays low, further clocking streams the next word.
- R4: If chip select rises before a word's sixteenth rising edge, the read pointer does not move, and the next read returns the same word again.
- R5: When the read pointer equals the write pointer, the word is the newest written result with the slot index it was written to, and the read pointer stays where it is.
- R6: A depth code k from 1 to 15 gives k+1 slots. The write pointer steps through 0..k and wraps to 0, one step per write strobe.
- R7: Depth code 0 disables the store. Writes are ignored, both pointers sit at 0, the interrupt flag is not set by writes, and every word read is all zeros.
- R8: The slot index in any word is at most the depth code. A change of the depth code restarts both pointers and the newest-result record at 0.
- R9: A write into the slot equal to irq_slot (0..15) sets irq, and irq stays set through further writes until a read starts.
- R10: A chip select falling edge (the start of any read) clears irq.
- R11: After reset, sdo and irq are 0, and a read returns the all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one converter result |
| wr_data | input | 12 | Converter result to store |
| depth_code | input | 4 | Depth code: 0 disables, k gives k+1 slots |
| irq_slot | input | 4 | Slot whose write raises the interrupt flag |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select from the host |
| sdo | output | 1 | Serial data to the host |
| irq | output | 1 | Interrupt flag |

## Verification
A wrong read or write pointer shows up in the low four bits of the very next complete word, since every word names its own slot. A pointer that moves on an aborted read shows up as a skipped index on the following read. A sequencer stuck in the wrong state either loses the bit alignment of the next word or fails to load it at the falling edge after the sixteenth bit, so a streamed multi-word read shows the fault one word later. Interrupt faults appear at the port within a few system clocks of the write strobe or of the chip select falling edge.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WORD_END
    } rd_state_e;
endpackage

// File: rtl/rfifo_sync_edge.sv
module rfifo_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic [STAGES-1:0] sck_s;
    logic [STAGES-1:0] cs_s;
    logic              sck_prev;
    logic              cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s    <= '0;
            cs_s     <= '1;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_s    <= {sck_s[STAGES-2:0], sck};
            cs_s     <= {cs_s[STAGES-2:0], cs_n};
            sck_prev <= sck_s[STAGES-1];
            cs_prev  <= cs_s[STAGES-1];
        end
    end

    assign sck_rise = sck_s[STAGES-1] & ~sck_prev;
    assign sck_fall = ~sck_s[STAGES-1] & sck_prev;
    assign cs_fall  = ~cs_s[STAGES-1] & cs_prev;
    assign cs_rise  = cs_s[STAGES-1] & ~cs_prev;
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
    parameter int DATA_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         depth_code,
    input  logic                     rd_adv,
    output logic [DATA_W+IDX_W-1:0]  ld_word,
    output logic                     rep,
    output logic                     cfg_chg,
    output logic                     enabled,
    output logic [IDX_W-1:0]         wr_ptr,
    output logic [IDX_W-1:0]         rd_ptr
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [SLOTS];
    logic [DATA_W-1:0] last_data_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic [IDX_W-1:0]  depth_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p,
                                              input logic [IDX_W-1:0] lim);
        return (p == lim) ? '0 : p + 1'b1;
    endfunction

    assign cfg_chg = (depth_code != depth_q);
    assign enabled = (depth_code != '0);
    assign rep     = (rd_ptr == wr_ptr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
            last_data_q <= '0;
            last_idx_q  <= '0;
            depth_q     <= '0;
            wr_ptr      <= '0;
            rd_ptr      <= '0;
        end else begin
            depth_q <= depth_code;
            if (cfg_chg) begin
                wr_ptr      <= '0;
                rd_ptr      <= '0;
                last_data_q <= '0;
                last_idx_q  <= '0;
            end else if (enabled) begin
                if (wr_en) begin
                    mem_q[wr_ptr] <= wr_data;
                    last_data_q   <= wr_data;
                    last_idx_q    <= wr_ptr;
                    wr_ptr        <= step(wr_ptr, depth_code);
                end
                if (rd_adv && !rep) rd_ptr <= step(rd_ptr, depth_code);
            end
        end
    end

    always_comb begin
        if (!enabled)
            ld_word = '0;
        else if (rep)
            ld_word = {last_data_q, last_idx_q};
        else
            ld_word = {mem_q[rd_ptr], rd_ptr};
    end
endmodule

// File: rtl/rfifo_top.sv
module rfifo_top
    import rfifo_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  depth_code,
    input  logic [IDX_W-1:0]  irq_slot,
    input  logic              sck,
    input  logic              cs_n,
    output logic              sdo,
    output logic              irq
);
    localparam int WORD_W = DATA_W + IDX_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rd_state_e         state_q, state_d;
    logic              sck_rise, sck_fall, cs_fall, cs_rise;
    logic [WORD_W-1:0] ld_word, shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              rep, cfg_chg, enabled, rd_adv, ld_pulse, irq_hit, shifting;
    logic [IDX_W-1:0]  wr_ptr, rd_ptr;

    rfifo_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    rfifo_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .depth_code(depth_code), .rd_adv(rd_adv), .ld_word(ld_word),
        .rep(rep), .cfg_chg(cfg_chg), .enabled(enabled),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    assign shifting = (state_q == ST_SHIFT);
    assign rd_adv   = shifting && sck_rise && !cs_rise && (bit_cnt_q == LAST_BIT);
    assign ld_pulse = ((state_q == ST_IDLE) && cs_fall) ||
                      ((state_q == ST_WORD_END) && sck_fall && !cs_rise);
    assign irq_hit  = wr_en && enabled && !cfg_chg && (wr_ptr == irq_slot);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:    if (cs_rise) state_d = ST_IDLE;
                         else if (rd_adv) state_d = ST_WORD_END;
            ST_WORD_END: if (cs_rise) state_d = ST_IDLE;
                         else if (sck_fall) state_d = ST_SHIFT;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            irq       <= 1'b0;
        end else begin
            if (ld_pulse) begin
                shreg_q   <= ld_word;
                bit_cnt_q <= '0;
            end else if (shifting && !cs_rise) begin
                if (sck_fall) shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                if (sck_rise && bit_cnt_q != LAST_BIT) bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (irq_hit)      irq <= 1'b1;
            else if (cs_fall) irq <= 1'b0;
        end
    end

    assign sdo = (state_q == ST_IDLE) ? 1'b0 : shreg_q[WORD_W-1];
endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] depth_code,
    input logic [IDX_W-1:0] irq_slot,
    input logic             irq,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             shifting,
    input logic             ld_pulse,
    input logic [IDX_W-1:0] ld_idx,
    input logic             cfg_chg,
    input logic [IDX_W-1:0] wr_ptr,
    input logic [IDX_W-1:0] rd_ptr
);
    AST_IRQ_ON_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && depth_code != '0 && !cfg_chg && wr_ptr == irq_slot) |=> irq); // R9
    AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !(wr_en && depth_code != '0 && !cfg_chg && wr_ptr == irq_slot)) |=> !irq); // R10
    AST_DISABLED_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_code == '0) |=> (wr_ptr == '0 && rd_ptr == '0)); // R7
    AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pulse && !cfg_chg) |-> (ld_idx <= depth_code)); // R8
    AST_WRAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (wr_ptr <= depth_code)); // R6
    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && shifting && !cfg_chg) |=> $stable(rd_ptr)); // R4
endmodule

bind rfifo_top rfifo_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .depth_code(depth_code),
    .irq_slot(irq_slot), .irq(irq), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .shifting(shifting), .ld_pulse(ld_pulse), .ld_idx(ld_word[IDX_W-1:0]),
    .cfg_chg(cfg_chg), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/rfifo_top_tb_top.sv
module rfifo_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [3:0]  depth_code = 4'd5;
    logic [3:0]  irq_slot = 4'd3;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdo, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] got_q[$];

    // reference model
    logic [11:0] m_mem [16];
    int          m_wr = 0, m_rd = 0, m_k = 5;
    logic [11:0] m_last = '0;
    int          m_last_idx = 0;

    always #5 clk = ~clk;

    rfifo_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .depth_code(depth_code), .irq_slot(irq_slot),
        .sck(sck), .cs_n(cs_n), .sdo(sdo), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nxt(input int p);
        return (p == m_k) ? 0 : p + 1;
    endfunction

    // driver side: expected word for the next complete read
    function automatic logic [15:0] model_read();
        logic [15:0] w;
        if (m_k == 0) return 16'h0000;
        if (m_rd == m_wr) return {m_last, 4'(m_last_idx)};
        w = {m_mem[m_rd], 4'(m_rd)};
        m_rd = nxt(m_rd);
        return w;
    endfunction

    task automatic do_write(input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (m_k != 0) begin
            m_mem[m_wr] = d; m_last = d; m_last_idx = m_wr; m_wr = nxt(m_wr);
        end
    endtask

    task automatic set_depth(input int k);
        @(negedge clk);
        depth_code = 4'(k);
        repeat (3) @(negedge clk);
        m_k = k; m_wr = 0; m_rd = 0; m_last = '0; m_last_idx = 0;
    endtask

    task automatic spi_bit(output logic b, output bit steady);
        b = sdo;
        sck = 1'b1;
        repeat (5) @(negedge clk);
        steady = (sdo == b);
        sck = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic spi_read(input int nwords, input string tag);
        logic [15:0] w;
        logic        b;
        bit          st, all_st;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int n = 0; n < nwords; n++) begin
            exp_q.push_back(model_read());
            tag_q.push_back(tag);
            w = '0; all_st = 1;
            for (int i = 0; i < 16; i++) begin
                spi_bit(b, st);
                w = {w[14:0], b};
                all_st &= st;
            end
            got_q.push_back(w);
            check(all_st, "R2 sdo steady while sck high", {15'd0, all_st}, 16'd1);
        end
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo == 1'b0, "R2 sdo low with cs high", {15'd0, sdo}, 16'd0);
    endtask

    task automatic spi_abort(input int nbits);
        logic b;
        bit   st;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) spi_bit(b, st);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // monitor: compares produced words against the scoreboard queue
    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [15:0] g, e;
            string t;
            g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
            check(g == e, t, g, e);
            check(g[3:0] <= 4'(m_k), "R8 index within depth", {12'd0, g[3:0]}, 16'(m_k));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo == 1'b0, "R11 sdo after reset", {15'd0, sdo}, 16'd0);
        check(irq == 1'b0, "R11 irq after reset", {15'd0, irq}, 16'd0);
        spi_read(1, "R11 empty read after reset");

        do_write(12'hA11); do_write(12'hB22); do_write(12'hC33);
        check(irq == 1'b0, "R9 irq idle before slot", {15'd0, irq}, 16'd0);
        do_write(12'hD44);
        check(irq == 1'b1, "R9 irq on slot write", {15'd0, irq}, 16'd1);
        do_write(12'hE55);
        check(irq == 1'b1, "R9 irq held", {15'd0, irq}, 16'd1);

        spi_read(2, "R1 R3 streamed words");
        check(irq == 1'b0, "R10 irq cleared by read", {15'd0, irq}, 16'd0);

        spi_abort(7);
        spi_read(1, "R4 aborted word repeats");

        spi_read(3, "R5 catch-up repeats newest");
        spi_read(1, "R5 repeat again");

        do_write(12'h161); do_write(12'h272); do_write(12'h383); do_write(12'h494);
        check(irq == 1'b0, "R9 no irq off slot", {15'd0, irq}, 16'd0);
        spi_read(4, "R6 wrap over slots");

        set_depth(0);
        do_write(12'hFFF); do_write(12'h123); do_write(12'h456); do_write(12'h789);
        check(irq == 1'b0, "R7 disabled writes no irq", {15'd0, irq}, 16'd0);
        spi_read(2, "R7 disabled reads zero");

        set_depth(2);
        do_write(12'h0AB); do_write(12'h0CD); do_write(12'h0EF); do_write(12'h321);
        spi_read(2, "R8 R6 short depth wrap");

        repeat (20) @(negedge clk);
        check(got_q.size() == 0 && exp_q.size() == 0, "R3 scoreboard drained",
              16'(got_q.size()), 16'd0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule